// File: doc/BRIEF.md
# Packed Half-to-Single Float Expander

This block widens a 64-bit word holding four 16-bit floating-point numbers into a 128-bit word holding four 32-bit floating-point numbers. Lane `i` of the input sits in bits `16*i+15 .. 16*i`. Its result sits in bits `32*i+31 .. 32*i` of the output. Each lane is converted on its own by integer logic. Normal numbers get a constant exponent re-bias and a mantissa shift. Subnormal numbers go through a leading-one finder that normalises them exactly. Zeros keep their sign. No rounding is needed, because every finite half value has an exact single-precision form.

The block is meant for a datapath that holds finite data only. Lanes whose 5-bit exponent field is all ones (infinities and NaNs) give an unspecified result. A valid flag travels with the data. With the default parameter setting, one register stage sits between input and output. That stage has a synchronous reset which clears the valid flag. The stage can be removed by parameter, which leaves a purely combinational path.

Top module: `hx_expand4`

## Requirements
- R1: Input lane i (bits 16*i+15..16*i) converts into output lane i (bits 32*i+31..32*i), and lanes do not affect each other.
- R2: Output bit 31 of a lane equals input bit 15 of that lane.
- R3: For an input exponent field e in 1..30 and mantissa m, the output exponent field (bits 30:23) is e+112 and the output bits 22:0 are m followed by 13 zero bits.
- R4: For an exponent field of 0 and a nonzero mantissa m, the output is the exact normalised single-precision encoding of m*2^-24, with an exponent field between 103 and 112.
- R5: 0x0000 becomes 0x00000000 and 0x8000 becomes 0x80000000.
- R6: The following encodings convert as listed: 0x0400 (smallest normal) becomes 0x38800000, 0x7BFF (65504) becomes 0x477FE000, and 0x1400 (2^-10) becomes 0x3A800000.
- R7: With the register stage present, out_valid equals the in_valid of the previous clock edge. When out_valid is high, out_data is the conversion of the in_data captured at that edge.
- R8: While rst is high at a clock edge, out_valid is low after that edge, even if in_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word is valid |
| in_data | input | 64 | Four packed 16-bit floats, lane 0 in bits 15:0 |
| out_valid | output | 1 | Output word is valid |
| out_data | output | 128 | Four packed 32-bit floats, lane 0 in bits 31:0 |

## Verification
The bench sweeps all 1024 subnormal mantissas. A normaliser with an off-by-one shift or a wrong exponent base would produce values that are twice or half the right size, and the smallest mantissa values expose a leading-one finder that misses bit 0. Signed zeros and the mantissa value 1 are driven together in one word, so that a design which sends zero down the subnormal path, or drops the sign there, is reported. The bench drives distinct values in every lane and leaves gaps in the valid stream, which catches swapped lanes and a valid flag that sticks or runs a cycle late. It also asserts reset while valid data is arriving, which shows a reset that fails to clear the flag.

// File: rtl/hx_pkg.sv
package hx_pkg;
    localparam int HX_HALF_W   = 16;
    localparam int HX_SINGLE_W = 32;
    localparam int HX_MAN_H    = 10;
    localparam int HX_EXP_H    = 5;
    localparam int HX_MAN_S    = 23;
    localparam int HX_EXP_S    = 8;
    localparam int HX_BIAS_H   = 15;
    localparam int HX_BIAS_S   = 127;
    // Constant added to a normal exponent field.
    localparam int HX_REBIAS   = HX_BIAS_S - HX_BIAS_H;
    // Exponent field of a subnormal whose leading one is at bit 0.
    localparam int HX_SUB_BASE = HX_BIAS_S - (HX_BIAS_H - 1 + HX_MAN_H);
    localparam int HX_POS_W    = $clog2(HX_MAN_H);
    localparam int HX_DEF_LANES = 4;
endpackage

// File: rtl/hx_lead.sv
module hx_lead #(
    parameter int W  = 10,
    localparam int PW = $clog2(W)
) (
    input  logic [W-1:0]  vec_i,
    output logic [PW-1:0] pos_o
);
    // Position of the highest set bit; zero when vec_i is zero.
    always_comb begin
        pos_o = '0;
        for (int i = 0; i < W; i++) begin
            if (vec_i[i]) pos_o = PW'(i);
        end
    end
endmodule

// File: rtl/hx_lane.sv
module hx_lane
    import hx_pkg::*;
(
    input  logic [HX_HALF_W-1:0]   h_i,
    output logic [HX_SINGLE_W-1:0] f_o
);
    logic                  sgn;
    logic [HX_EXP_H-1:0]   exp_h;
    logic [HX_MAN_H-1:0]   man_h;
    logic [HX_POS_W-1:0]   lead_pos;
    logic [HX_SINGLE_W-1:0] norm_w;
    logic [HX_SINGLE_W-1:0] sub_w;
    logic [HX_SINGLE_W-1:0] sub_shift;
    logic [HX_EXP_S-1:0]    sub_exp;
    logic [HX_SINGLE_W-1:0] mag_w;

    assign sgn   = h_i[HX_HALF_W-1];
    assign exp_h = h_i[HX_HALF_W-2 -: HX_EXP_H];
    assign man_h = h_i[HX_MAN_H-1:0];

    hx_lead #(.W(HX_MAN_H)) u_lead (
        .vec_i (man_h),
        .pos_o (lead_pos)
    );

    always_comb begin
        // Normal path: align mantissa, add exponent re-bias.
        norm_w = (HX_SINGLE_W'(h_i[HX_HALF_W-2:0]) << (HX_MAN_S - HX_MAN_H))
               + (HX_SINGLE_W'(HX_REBIAS) << HX_MAN_S);
        // Subnormal path: move the leading one to the hidden-bit slot.
        sub_exp   = HX_EXP_S'(lead_pos) + HX_EXP_S'(HX_SUB_BASE);
        sub_shift = HX_SINGLE_W'(man_h) << (5'(HX_MAN_S) - 5'(lead_pos));
        sub_w     = {1'b0, sub_exp, sub_shift[HX_MAN_S-1:0]};
        if (exp_h != '0)       mag_w = norm_w;
        else if (man_h != '0)  mag_w = sub_w;
        else                   mag_w = '0;
        f_o = {sgn, mag_w[HX_SINGLE_W-2:0]};
    end

    always_comb begin
        if (!$isunknown(h_i)) begin
            if (exp_h != '0 && exp_h != '1) begin
                a_r3_normal_fields: assert (f_o[30:23] == 8'(exp_h) + 8'(HX_REBIAS)
                                            && f_o[22:0] == {man_h, 13'b0});
            end
            if (exp_h == '0 && man_h != '0) begin
                a_r4_sub_range: assert (f_o[30:23] >= 8'(HX_SUB_BASE)
                                        && f_o[30:23] < 8'(HX_SUB_BASE + HX_MAN_H));
            end
            if (h_i[HX_HALF_W-2:0] == '0) begin
                a_r5_zero_mag: assert (f_o[HX_SINGLE_W-2:0] == '0);
            end
        end
    end
endmodule

// File: rtl/hx_expand4.sv
module hx_expand4
    import hx_pkg::*;
#(
    parameter int LANES   = HX_DEF_LANES,
    parameter bit REG_OUT = 1'b1,
    localparam int IN_W  = LANES * HX_HALF_W,
    localparam int OUT_W = LANES * HX_SINGLE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_data,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_data
);
    typedef struct packed {
        logic             valid;
        logic [OUT_W-1:0] data;
    } stage_t;

    logic [OUT_W-1:0] conv;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        hx_lane u_lane (
            .h_i (in_data[g*HX_HALF_W +: HX_HALF_W]),
            .f_o (conv[g*HX_SINGLE_W +: HX_SINGLE_W])
        );
    end

    stage_t st_d;

    always_comb begin
        st_d.valid = in_valid;
        st_d.data  = conv;
    end

    if (REG_OUT) begin : g_reg
        stage_t st_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                st_q.valid <= 1'b0;
            end else begin
                st_q.valid <= st_d.valid;
            end
            if (st_d.valid) st_q.data <= st_d.data;
        end

        assign out_valid = st_q.valid;
        assign out_data  = st_q.data;

        a_r7_valid_rise: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> out_valid);
        a_r7_valid_idle: assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> !out_valid);
        a_r7_data_hold: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> out_data == $past(conv));
        a_r8_reset_clear: assert property (@(posedge clk)
            rst |=> !out_valid);
    end else begin : g_comb
        assign out_valid = st_d.valid;
        assign out_data  = st_d.data;
    end
endmodule

// File: tb/tb_hx_expand4.sv
`timescale 1ns/1ps
module tb_hx_expand4;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [63:0]  in_data = '0;
    logic         out_valid;
    logic [127:0] out_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [127:0] exp_q[$];
    string        tag_q[$];

    always #2.5 clk = ~clk;

    hx_expand4 dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    function automatic logic [31:0] ref_f(input logic [15:0] h);
        logic        s;
        int          e;
        int          ex;
        logic [10:0] mm;
        s  = h[15];
        e  = int'(h[14:10]);
        mm = {1'b0, h[9:0]};
        if (e == 0 && mm == 0) return {s, 31'b0};
        if (e != 0) return {s, 8'(e - 15 + 127), h[9:0], 13'b0};
        ex = -14;
        while (!mm[10]) begin
            mm = mm << 1;
            ex = ex - 1;
        end
        return {s, 8'(ex + 127), mm[9:0], 13'b0};
    endfunction

    function automatic logic [127:0] ref_word(input logic [63:0] w);
        logic [127:0] r;
        for (int i = 0; i < 4; i++) r[i*32 +: 32] = ref_f(w[i*16 +: 16]);
        return r;
    endfunction

    task automatic send(input logic [63:0] w, input string tag);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = w;
        exp_q.push_back(ref_word(w));
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_data  = 64'hDEAD_BEEF_0BAD_F00D;
        end
    endtask

    task automatic fail_line(input string tag, input logic [127:0] act, input logic [127:0] expv);
        errors++;
        $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Monitor / scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (!done) begin
                logic [127:0] e;
                string t;
                checks++;
                if (rst) begin
                    if (in_valid) begin
                        void'(exp_q.pop_front());
                        void'(tag_q.pop_front());
                    end
                    if (out_valid !== 1'b0) fail_line("R8 valid under reset", 128'(out_valid), 128'(0));
                end else begin
                    if (out_valid !== in_valid)
                        fail_line("R7 valid timing", 128'(out_valid), 128'(in_valid));
                    if (in_valid && exp_q.size() > 0) begin
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        checks++;
                        if (out_data !== e) fail_line(t, out_data, e);
                    end
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        // Reset state (R8)
        repeat (3) @(negedge clk);
        rst = 1'b0;
        idle(2);

        // R6 reference encodings plus 1.0
        send(64'h3C00_0400_7BFF_1400, "R6 reference encodings");
        // R5 signed zeros next to smallest subnormals
        send(64'h0001_8001_0000_8000, "R5 signed zeros");
        idle(1);
        // R1 distinct lanes, R2 sign per lane
        send(64'h8400_4000_C500_0123, "R1 lane placement");
        send(64'h0123_C500_4000_8400, "R2 sign per lane");

        // R4 every subnormal mantissa
        for (int k = 0; k < 256; k++) begin
            logic [63:0] w;
            for (int l = 0; l < 4; l++) begin
                logic [9:0] m;
                m = 10'(k*4 + l);
                w[l*16 +: 16] = {1'(l & 1), 5'd0, m};
            end
            send(w, "R4 subnormal sweep");
            if (k % 37 == 5) idle(1);
        end

        // R3 normal exponents
        for (int e = 1; e <= 30; e++) begin
            for (int k = 0; k < 4; k++) begin
                logic [63:0] w;
                for (int l = 0; l < 4; l++) begin
                    logic [9:0] m;
                    m = 10'((e*37 + k*251 + l*97) % 1024);
                    w[l*16 +: 16] = {1'((k + l) & 1), 5'(e), m};
                end
                send(w, "R3 normal sweep");
            end
            if (e % 7 == 0) idle(2);
        end

        // R8 reset while valid data arrives
        send(64'h3C00_3C00_3C00_3C00, "R8 before reset");
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b1;
        in_data = 64'h4000_4000_4000_4000;
        exp_q.push_back(ref_word(in_data));
        tag_q.push_back("R8 dropped");
        @(negedge clk);
        rst = 1'b0;
        in_valid = 1'b0;
        send(64'h7BFF_0400_1400_0000, "R7 after reset");
        idle(3);

        done = 1'b1;
        checks++;
        if (exp_q.size() != 0) fail_line("R7 leftover results", 128'(exp_q.size()), 128'(0));
        summary();
    end
endmodule